// File: doc/BRIEF.md
# Protected Power-of-Two Clock Prescaler

This block divides a source clock by a power of two, from 1 up to 256. Its output is a one-cycle clock-enable pulse. A counter that runs on the undivided source clock drives the pulse, and the pulse is registered. Everything downstream therefore stays in the source clock domain and gates itself with the pulse. No derived clock net is created.

Software can change the division only through a guarded two-step write on a simple byte-wide write port:

1. A write of exactly `0x80` arms a short unlock window.
2. A second write with the top bit clear, arriving inside that window, supplies the new 4-bit select value.

Any other write has no effect on the setting. An accepted setting is first held as pending. It replaces the active one at the end of the divided period that is running. No pulse interval can therefore be shorter than the old period or the new one. The window state and the requested setting can be read back at any time on the read port.

Top module: `clk_prescaler`

## Requirements
- R1: While reset is asserted, `clk_en` is low. After reset the select value is 3 (divide by 8) when `SHIP_DEFAULT` is 1, and 0 (divide by 1) otherwise. `rd_data` then reads the select in bits 3:0 with all other bits zero.
- R2: Only a write of exactly `0x80` (bit 7 set, bits 6:0 zero) opens the unlock window. While the window is open, `rd_data[7]` reads 1.
- R3: The select write (bit 7 clear, bits 3:0 the select) is accepted only at the 1st to 4th clock edge after the edge that took the `0x80` write. Any write at one of those edges closes the window, and a select write at a later edge is ignored.
- R4: Select values 9 to 15 are reserved. Such a write leaves the setting unchanged and still closes the window.
- R5: With select value s in 0..8, `clk_en` is a one-cycle pulse every 2^s source cycles. With s = 0 it is high on every cycle.
- R6: An accepted setting takes effect at the end of the current divided period. The interval ending at the first pulse after the accepting edge keeps the old length, and every later interval has the new length. When several settings are accepted inside one period, only the last one counts.
- R7: `rd_data[3:0]` shows the most recently accepted select from the clock edge that accepted it, even while that select is still pending. `rd_data[6:4]` always read zero.
- R8: A select write made while no window is open has no effect.
- R9: A write with bit 7 set and any of bits 6:0 nonzero, such as `0x81`, does not open the window, and a select write that follows it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Undivided source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the setting port |
| wr_data | input | 8 | Write data: bit 7 is change-enable, bits 3:0 are the select |
| clk_en | output | 1 | Registered divided clock-enable pulse |
| rd_data | output | 8 | Bit 7 is the window-open flag, bits 3:0 are the requested select |

## Verification
The bench measures the spacing between every pair of enable pulses. It drives the following patterns:
- select writes landing on the last edge inside the window and on the first edge past it;
- reserved select values, malformed unlock bytes and unguarded writes;
- switches to divide-by-1 and to divide-by-256;
- two settings accepted inside one long period.

The window-edge pair separates a correct four-cycle window from one that is a cycle short or long. The malformed and unguarded writes show up as a pulse spacing or a readback that should not have changed. The double switch inside a long period separates switching at the period boundary from switching at once: an early switch would give an interval shorter than the old period, and a wrong choice of setting would give the wrong new length.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int SEL_W   = 4;
    localparam int MAX_SEL = 8;
    localparam int CNT_W   = MAX_SEL;
    localparam int DATA_W  = 8;
    localparam int CE_BIT  = DATA_W - 1;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic open_req;   // exact unlock byte
        logic sel_write;  // change-enable clear
        sel_t sel;
    } wr_dec_t;

    function automatic logic sel_ok(sel_t s);
        return s <= sel_t'(MAX_SEL);
    endfunction

    function automatic cnt_t last_count(sel_t s);
        return cnt_t'((32'd1 << s) - 32'd1);
    endfunction

    function automatic wr_dec_t decode_wr(byte_t d);
        wr_dec_t r;
        r.open_req  = d[CE_BIT] && (d[CE_BIT-1:0] == '0);
        r.sel_write = !d[CE_BIT];
        r.sel       = d[SEL_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/psc_unlock.sv
module psc_unlock
    import psc_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    output logic  win_open,
    output logic  accept,
    output sel_t  new_sel
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);

    logic [WIN_W-1:0] win_q;
    wr_dec_t          dec;

    always_comb begin
        dec      = decode_wr(wr_data);
        win_open = (win_q != '0);
        accept   = wr_en && win_open && dec.sel_write && sel_ok(dec.sel);
        new_sel  = dec.sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (wr_en && dec.open_req) begin
            win_q <= WIN_W'(WIN_CYC);
        end else if (wr_en) begin
            win_q <= '0;
        end else if (win_q != '0) begin
            win_q <= win_q - 1'b1;
        end
    end

    // R3: the window never holds more than its configured length
    p_win_bound_r3: assert property (@(posedge clk) disable iff (rst)
        win_q <= WIN_W'(WIN_CYC));

    // R3: any write other than the unlock byte leaves the window closed
    p_write_closes_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.open_req) |=> !win_open);

    // R9: the window only opens after the exact unlock byte
    p_open_source_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(win_open) |-> $past(wr_en && wr_data == 8'h80));

endmodule

// File: rtl/psc_divider.sv
module psc_divider
    import psc_pkg::*;
#(
    parameter sel_t RESET_SEL = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  sel_t new_sel,
    output logic clk_en,
    output sel_t target
);

    cnt_t cnt_q;
    sel_t cur_q, pend_q;
    logic pend_v_q, clk_en_q;
    logic tick, apply_now;
    sel_t apply_sel;

    always_comb begin
        tick      = (cnt_q == last_count(cur_q));
        apply_now = accept || pend_v_q;
        apply_sel = accept ? new_sel : pend_q;
        target    = pend_v_q ? pend_q : cur_q;
        clk_en    = clk_en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            cur_q    <= RESET_SEL;
            pend_q   <= RESET_SEL;
            pend_v_q <= 1'b0;
            clk_en_q <= 1'b0;
        end else begin
            clk_en_q <= tick;
            cnt_q    <= tick ? '0 : cnt_q + 1'b1;
            if (tick) begin
                if (apply_now) cur_q <= apply_sel;
                pend_v_q <= 1'b0;
            end else if (accept) begin
                pend_q   <= new_sel;
                pend_v_q <= 1'b1;
            end
        end
    end

    // checker state: cycles since the previous pulse
    logic             seen_q;
    logic [CNT_W:0]   gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            gap_q  <= '0;
        end else if (clk_en_q) begin
            seen_q <= 1'b1;
            gap_q  <= (CNT_W+1)'(1);
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R5/R6: each interval matches the setting that was active while it ran
    p_interval_r6: assert property (@(posedge clk) disable iff (rst)
        (clk_en_q && seen_q) |->
            (gap_q == (CNT_W+1)'(last_count($past(cur_q))) + 1'b1));

    // R6: the active setting only moves where a divided period ends
    p_switch_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> clk_en_q);

    // R7: the requested setting only moves on an accepted write
    p_target_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(target));

endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler
    import psc_pkg::*;
#(
    parameter bit SHIP_DEFAULT = 1'b0,
    parameter int WIN_CYC      = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       clk_en,
    output logic [7:0] rd_data
);

    localparam sel_t RESET_SEL = SHIP_DEFAULT ? sel_t'(3) : sel_t'(0);

    logic win_open, accept;
    sel_t new_sel, target;

    psc_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .win_open (win_open),
        .accept   (accept),
        .new_sel  (new_sel)
    );

    psc_divider #(.RESET_SEL(RESET_SEL)) u_div (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .new_sel (new_sel),
        .clk_en  (clk_en),
        .target  (target)
    );

    assign rd_data = {win_open, {(DATA_W-1-SEL_W){1'b0}}, target};

    // R1: no pulse while reset is held
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> !clk_en);

endmodule

// File: tb/sim_clk_prescaler.sv
`timescale 1ns/1ps
module sim_clk_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clk_en, clk_en1;
    logic [7:0] rd_data, rd_data1;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];
    int exp_p = 1;
    int cyc = 0;
    int prev = 0;
    bit have_prev = 0;

    always #2.5 clk = ~clk;

    clk_prescaler u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
                      .clk_en(clk_en), .rd_data(rd_data));
    clk_prescaler #(.SHIP_DEFAULT(1'b1)) u1 (.clk(clk), .rst(rst), .wr_en(1'b0),
                      .wr_data(8'h00), .clk_en(clk_en1), .rd_data(rd_data1));

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic rd_chk(input string tag, input int expv);
        @(negedge clk);
        chk(rd_data == expv[7:0], tag, rd_data, expv);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // monitor: scoreboard of pulse intervals
    always @(negedge clk) begin
        if (rst) begin
            have_prev = 0;
            cyc = 0;
        end else begin
            cyc++;
            if (clk_en) begin
                if (have_prev)
                    chk((cyc - prev) == exp_p, "R5 R6 pulse interval", cyc - prev, exp_p);
                prev = cyc;
                have_prev = 1;
                while (exp_q.size() > 0) exp_p = exp_q.pop_front();
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(clk_en == 1'b0, "R1 clk_en low in reset", clk_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == 8'h00, "R1 reset select default", rd_data, 0);
        chk(rd_data1 == 8'h03, "R1 reset select shipped", rd_data1, 3);
        idle(10);

        // R2 window flag, R7 readback, R3 immediate accept: divide by 8
        wr(8'h80);
        rd_chk("R2 window open flag", 8'h80);
        wr(8'h03); exp_q.push_back(8);
        rd_chk("R7 readback after accept", 8'h03);
        idle(40);

        // R3: accepted on the 4th edge after the unlock
        wr(8'h80); idle(3); wr(8'h05); exp_q.push_back(32);
        rd_chk("R3 last window edge accepted", 8'h05);
        idle(100);

        // R3: ignored on the 5th edge
        wr(8'h80); idle(4); wr(8'h02);
        rd_chk("R3 write after window ignored", 8'h05);
        idle(100);

        // R4: reserved select ignored, window closed
        wr(8'h80); wr(8'h0B);
        rd_chk("R4 reserved select ignored", 8'h05);
        wr(8'h80); wr(8'h0C); wr(8'h01);
        rd_chk("R4 reserved write closes window", 8'h05);
        idle(70);

        // R8: no unlock
        wr(8'h02);
        rd_chk("R8 unguarded write ignored", 8'h05);
        idle(70);

        // R9: malformed unlock
        wr(8'h81);
        rd_chk("R9 malformed unlock keeps window shut", 8'h05);
        wr(8'h01);
        rd_chk("R9 select after malformed unlock ignored", 8'h05);
        idle(70);

        // R5: divide by 1
        wr(8'h80); wr(8'h00); exp_q.push_back(1);
        rd_chk("R5 select zero readback", 8'h00);
        idle(20);

        // R5: divide by 256
        wr(8'h80); wr(8'h08); exp_q.push_back(256);
        idle(800);

        // R6: two changes inside one long period, last one wins
        do @(negedge clk); while (!clk_en);
        wr(8'h80); wr(8'h02); exp_q.push_back(4);
        wr(8'h80); wr(8'h01); exp_q.push_back(2);
        rd_chk("R7 readback of latest pending select", 8'h01);
        idle(600);
        chk(exp_q.size() == 0, "R6 all switches took effect", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule